// File: doc/BRIEF.md
# Transmit Descriptor Ring Tracker

The block keeps the bookkeeping for a circular ring of 16-byte transmit descriptors. Software programs the ring size in bytes and moves a tail index forward to hand descriptors to the transmitter. The transmit engine sends a one-cycle pulse each time it finishes a descriptor, and the block then moves the head index forward. Both indices count whole descriptors and wrap to zero at the end of the ring.

The block reports to the transmit engine whether work is waiting, how many descriptors are waiting, and which descriptor comes next. It rejects illegal configuration. A ring size that is badly aligned or too small is ignored. A head write while transmit is enabled is ignored. A pointer value beyond the ring is ignored. Each rejection sets a sticky error flag, so a wrong write never disturbs the live pointers.

Registers are reached through a simple word-indexed bus. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from the current state.

Top module: `tx_ring_tracker`

## Requirements
- R1: After reset the ring length is 128 bytes (8 descriptors), head and tail are 0, the ring is empty, and both error flags are clear.
- R2: Word 0 holds the ring length in bits 19:0. A write while `tx_en` is low, with bits 6:0 zero and a value of at least 128, is accepted and clears head and tail to 0. Reads return the length with bits 31:20 and 6:0 zero.
- R3: A length write that has bits 6:0 nonzero, is below 128, or arrives while `tx_en` is high leaves the length and pointers unchanged and sets `cfg_err`. `cfg_err` stays set until reset.
- R4: Word 2 holds the tail in bits 15:0. A write whose value is below the ring size (length/16) updates the tail in any transmit state. Reads return zero in bits 31:16.
- R5: Word 1 holds the head in bits 15:0. A write while `tx_en` is low, with a value below the ring size, updates the head. Reads return zero in bits 31:16.
- R6: A head write while `tx_en` is high leaves the head unchanged and sets `ptr_err`. `ptr_err` stays set until reset.
- R7: A head or tail write whose value is at or above the ring size leaves that pointer unchanged and sets `ptr_err`.
- R8: A `desc_done` pulse while `tx_en` is high and the ring is not empty advances the head by one. From size-1 the head goes to 0.
- R9: A `desc_done` pulse while the ring is empty or `tx_en` is low has no effect.
- R10: `next_index` equals the head. `ring_empty` is high exactly when head equals tail. `pending_count` equals (tail − head) modulo the ring size.
- R11: Word 3 is unmapped. It reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| desc_done | input | 1 | Descriptor completed pulse from the transmit engine |
| next_index | output | 16 | Index of the next descriptor to process |
| pending_count | output | 16 | Descriptors waiting between head and tail |
| ring_empty | output | 1 | Head equals tail |
| cfg_err | output | 1 | Sticky illegal length write flag |
| ptr_err | output | 1 | Sticky illegal pointer write flag |

## Verification
Completion pulses are driven against rings of 8, 16, 24 and 32 entries. Tails are placed both above and below the head, which separates a correct modulo count from a plain subtraction and exercises the wrap from size-1 to 0.

Several write patterns are mixed with enabled and disabled phases:
- lengths that are misaligned, too small, or written while enabled;
- head writes while enabled;
- pointer values just past the ring end.

These patterns show whether each guard depends on the right condition. Completion pulses on an empty or disabled ring confirm that the head holds its value.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int unsigned PTR_W = 16;
  localparam int unsigned DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int unsigned ALIGN_BITS = 7;   // 128-byte granularity

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    SEL_LEN  = 2'd0,
    SEL_HEAD = 2'd1,
    SEL_TAIL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // step an index forward by one within a ring of the given size
  function automatic ptr_t ring_next(ptr_t p, ptr_t size);
    return (p == size - ptr_t'(1)) ? '0 : p + ptr_t'(1);
  endfunction

  // descriptors waiting from head up to but not including tail
  function automatic ptr_t ring_fill(ptr_t head, ptr_t tail, ptr_t size);
    if (tail >= head) return tail - head;
    return tail + (size - head);
  endfunction
endpackage

// File: rtl/tx_ring_regif.sv
module tx_ring_regif
  import tx_ring_pkg::*;
#(
  parameter int unsigned LEN_W = 20
) (
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [LEN_W-1:0] ring_len,
  input  ptr_t             head,
  input  ptr_t             tail,
  output logic             len_we,
  output logic             head_we,
  output logic             tail_we,
  output logic [31:0]      reg_rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  assign len_we  = reg_wr && (sel == SEL_LEN);
  assign head_we = reg_wr && (sel == SEL_HEAD);
  assign tail_we = reg_wr && (sel == SEL_TAIL);

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_LEN:  reg_rdata[LEN_W-1:0] = ring_len;
      SEL_HEAD: reg_rdata[PTR_W-1:0] = head;
      SEL_TAIL: reg_rdata[PTR_W-1:0] = tail;
      SEL_NONE: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tx_ring_len.sv
module tx_ring_len
  import tx_ring_pkg::*;
#(
  parameter int unsigned LEN_W     = 20,
  parameter int unsigned RESET_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             len_we,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] ring_len,
  output ptr_t             ring_size,
  output logic             len_accept,
  output logic             len_reject,
  output logic             cfg_err
);
  localparam int unsigned MIN_LEN = 1 << ALIGN_BITS;

  logic aligned, big_enough;
  assign aligned    = (wdata[ALIGN_BITS-1:0] == '0);
  assign big_enough = (wdata >= LEN_W'(MIN_LEN));
  assign len_accept = len_we && !tx_en && aligned && big_enough;
  assign len_reject = len_we && !len_accept;

  assign ring_size = ptr_t'(ring_len >> DESC_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_len <= LEN_W'(RESET_LEN);
      cfg_err  <= 1'b0;
    end else begin
      if (len_accept) ring_len <= wdata;
      if (len_reject) cfg_err  <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_ring_ptrs.sv
module tx_ring_ptrs
  import tx_ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic desc_done,
  input  logic head_we,
  input  logic tail_we,
  input  ptr_t wval,
  input  ptr_t ring_size,
  input  logic len_accept,
  output ptr_t head,
  output ptr_t tail,
  output logic empty,
  output ptr_t fill,
  output logic head_adv,
  output logic head_wr_ok,
  output logic tail_wr_ok,
  output logic ptr_reject,
  output logic ptr_err
);
  logic in_range;
  assign in_range   = (wval < ring_size);
  assign empty      = (head == tail);
  assign fill       = ring_fill(head, tail, ring_size);
  assign head_adv   = desc_done && tx_en && !empty;
  assign head_wr_ok = head_we && !tx_en && in_range;
  assign tail_wr_ok = tail_we && in_range;
  assign ptr_reject = (head_we && !head_wr_ok) || (tail_we && !tail_wr_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      ptr_err <= 1'b0;
    end else begin
      if (len_accept) begin
        head <= '0;
        tail <= '0;
      end else begin
        if (head_wr_ok)    head <= wval;
        else if (head_adv) head <= ring_next(head, ring_size);
        if (tail_wr_ok)    tail <= wval;
      end
      if (ptr_reject) ptr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_ring_tracker.sv
module tx_ring_tracker
  import tx_ring_pkg::*;
#(
  parameter int unsigned LEN_W     = 20,
  parameter int unsigned RESET_LEN = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        desc_done,
  output logic [15:0] next_index,
  output logic [15:0] pending_count,
  output logic        ring_empty,
  output logic        cfg_err,
  output logic        ptr_err
);
  logic             len_we, head_we, tail_we;
  logic [LEN_W-1:0] ring_len;
  ptr_t             ring_size, head, tail, fill;
  logic             len_accept, len_reject;
  logic             head_adv, head_wr_ok, tail_wr_ok, ptr_reject;
  logic             empty;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[31:LEN_W];

  tx_ring_regif #(.LEN_W(LEN_W)) u_regif (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .ring_len(ring_len),
    .head(head), .tail(tail), .len_we(len_we), .head_we(head_we),
    .tail_we(tail_we), .reg_rdata(reg_rdata)
  );

  tx_ring_len #(.LEN_W(LEN_W), .RESET_LEN(RESET_LEN)) u_len (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .len_we(len_we),
    .wdata(reg_wdata[LEN_W-1:0]), .ring_len(ring_len), .ring_size(ring_size),
    .len_accept(len_accept), .len_reject(len_reject), .cfg_err(cfg_err)
  );

  tx_ring_ptrs u_ptrs (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .desc_done(desc_done),
    .head_we(head_we), .tail_we(tail_we), .wval(reg_wdata[PTR_W-1:0]),
    .ring_size(ring_size), .len_accept(len_accept), .head(head), .tail(tail),
    .empty(empty), .fill(fill), .head_adv(head_adv), .head_wr_ok(head_wr_ok),
    .tail_wr_ok(tail_wr_ok), .ptr_reject(ptr_reject), .ptr_err(ptr_err)
  );

  assign next_index    = head;
  assign pending_count = fill;
  assign ring_empty    = empty;
endmodule

// File: rtl/tx_ring_tracker_chk.sv
module tx_ring_tracker_chk
  import tx_ring_pkg::*;
#(
  parameter int unsigned LEN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             desc_done,
  input logic [15:0]      next_index,
  input logic [15:0]      pending_count,
  input logic             ring_empty,
  input logic             cfg_err,
  input logic             ptr_err,
  input logic [LEN_W-1:0] ring_len,
  input ptr_t             ring_size,
  input logic             head_adv
);
  logic bad_len_wr;
  assign bad_len_wr = reg_wr && reg_addr == 2'd0 &&
                      (reg_wdata[6:0] != 7'd0 || reg_wdata[LEN_W-1:0] < LEN_W'(128) || tx_en);

  assert_head_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    next_index < ring_size);

  assert_head_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    head_adv |=> next_index == ring_next($past(next_index), $past(ring_size)));

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && !reg_wr && (!tx_en || ring_empty)) |=> $stable(next_index));

  assert_head_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && tx_en) |=> ($stable(next_index) && ptr_err));

  assert_bad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len_wr |=> ($stable(ring_len) && cfg_err));

  assert_cfg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_ptr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_err |=> ptr_err);

  assert_empty_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty == (pending_count == 16'd0));
endmodule

bind tx_ring_tracker tx_ring_tracker_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .desc_done(desc_done),
  .next_index(next_index), .pending_count(pending_count),
  .ring_empty(ring_empty), .cfg_err(cfg_err), .ptr_err(ptr_err),
  .ring_len(ring_len), .ring_size(ring_size), .head_adv(head_adv)
);

// File: tb/tx_ring_tracker_bench.sv
module tx_ring_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        desc_done = 1'b0;
  logic [15:0] next_index, pending_count;
  logic        ring_empty, cfg_err, ptr_err;

  int checks = 0;
  int errors = 0;
  int m_len = 128, m_head = 0, m_tail = 0, m_cfg = 0, m_perr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_tracker u_tx_ring_tracker (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_done(desc_done), .next_index(next_index),
    .pending_count(pending_count), .ring_empty(ring_empty),
    .cfg_err(cfg_err), .ptr_err(ptr_err)
  );

  function automatic int b_size();
    return m_len / 16;
  endfunction

  function automatic int b_fill();
    return (m_tail - m_head + b_size()) % b_size();
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R10 next_index"}, next_index, m_head);
    chk({tag, " R10 empty"}, ring_empty, (m_head == m_tail) ? 1 : 0);
    chk({tag, " R10 pending"}, pending_count, b_fill());
    chk({tag, " R3 cfg_err"}, cfg_err, m_cfg);
    chk({tag, " R6 ptr_err"}, ptr_err, m_perr);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      case (a)
        0: chk({tag, " R2 len read"}, reg_rdata, m_len);
        1: chk({tag, " R5 head read"}, reg_rdata, m_head);
        2: chk({tag, " R4 tail read"}, reg_rdata, m_tail);
        default: chk({tag, " R11 unmapped read"}, reg_rdata, 0);
      endcase
    end
  endtask

  // one clock with optional write and completion pulse; model updated alongside
  task automatic step(input string tag, input bit wr, input int a,
                      input longint d, input bit done, input bit en);
    int sz, fld, v;
    bit adv;
    @(negedge clk);
    tx_en = en; reg_wr = wr; reg_addr = 2'(a);
    reg_wdata = 32'(d); desc_done = done;
    sz  = b_size();
    adv = done && en && (m_head != m_tail);
    if (adv) m_head = (m_head + 1) % sz;
    if (wr) begin
      case (a)
        0: begin
          fld = int'(d & 64'hFFFFF);
          if (!en && (fld % 128) == 0 && fld >= 128) begin
            m_len = fld; m_head = 0; m_tail = 0;
          end else m_cfg = 1;
        end
        1: begin
          v = int'(d & 64'hFFFF);
          if (!en && v < sz) m_head = v; else m_perr = 1;
        end
        2: begin
          v = int'(d & 64'hFFFF);
          if (v < sz) m_tail = v; else m_perr = 1;
        end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0; desc_done = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int op;
    bit en;
    longint val;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset-asserted");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 after reset");

    // directed corner cases
    step("R2 len 256",            1, 0, 256, 0, 0);
    step("R4 tail 5",             1, 2, 5, 0, 0);
    step("R9 done disabled",      0, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) step("R8 drain", 0, 0, 0, 1, 1);
    step("R9 done empty",         0, 0, 0, 1, 1);
    step("R6 head write enabled", 1, 1, 3, 0, 1);
    m_cfg = 0;
    step("R3 len while enabled",  1, 0, 384, 0, 1);
    step("R3 len misaligned",     1, 0, 200, 0, 0);
    step("R3 len too small",      1, 0, 0, 0, 0);
    step("R5 head 14",            1, 1, 14, 0, 0);
    step("R4 tail 2 below head",  1, 2, 2, 0, 0);
    for (int i = 0; i < 4; i++) step("R8 wrap", 0, 0, 0, 1, 1);
    step("R7 tail past end",      1, 2, 16, 0, 0);
    step("R7 head past end",      1, 1, 16, 0, 0);
    step("R11 unmapped write",    1, 3, 32'hFFFF_FFFF, 0, 0);
    step("R2 len upper ignored",  1, 0, 64'hFFF0_0080, 0, 0);

    // constrained random mix
    en = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(9) == 0) en = ~en;
      op = $urandom_range(11);
      case (op)
        0: begin
          case ($urandom_range(6))
            0: val = 128; 1: val = 256; 2: val = 384; 3: val = 512;
            4: val = 64;  5: val = 130; default: val = $urandom_range(1023);
          endcase
          step("R2 rnd len", 1, 0, val, 0, en);
        end
        1, 2, 3: step("R4 rnd tail", 1, 2, $urandom_range(b_size() + 1), $urandom_range(1), en);
        4: step("R5 rnd head", 1, 1, $urandom_range(b_size() + 1), 0, en);
        5: step("R11 rnd unmapped", 1, 3, $urandom, $urandom_range(1), en);
        default: step("R8 rnd done", 0, 0, 0, 1, en);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule